// File: doc/BRIEF.md
# Interrupt Status Threshold Controller

This block gathers single-cycle event pulses from a USB-style controller into sticky status bits. Each status bit has an enable bit at the same position, and the block drives one merged interrupt line. Software clears a status bit by writing a one to it.

Two completion events are handled differently: the asynchronous-completion and periodic-completion events. They are not posted when they occur. They wait in a pending register and are moved into status at the next threshold boundary. A programmable number of micro-frame ticks marks that boundary. A threshold of zero turns the holding off, so these events are posted at once like every other event.

Register access uses a simple write port and a read port with a combinational read. Address 0 holds status, address 1 holds the enables, address 2 holds the threshold in bits 7:0, and address 3 reads as zero.

Top module: `irq_thr_ctrl`

## Requirements
- R1: After reset, status, enables and threshold all read 0 and `irq_o` is low.
- R2: An event pulse on an immediate bit (bits 0-8, 24, 25) sets that status bit on the next clock edge. The bit stays set after the pulse ends.
- R3: Writing a one to a status bit at address 0 clears it. Writing a zero leaves the bit unchanged.
- R4: `irq_o` is high exactly when some status bit and the enable bit at the same position are both one. An event on a disabled bit does not raise `irq_o`.
- R5: When an event and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R6: Status bit 16 mirrors the `nak_level` input. A write of one to bit 16 does not change it, and bit 16 takes part in the interrupt when enable bit 16 is set.
- R7: With a nonzero threshold N, completion events on bits 18 (asynchronous) and 19 (periodic) appear in status only on the clock edge of the N-th micro-frame tick after the threshold was written or after the previous boundary. The count then restarts.
- R8: With threshold 0, completion events set their status bits on the next edge. Events still pending when the threshold becomes 0 are posted on the edge after the change.
- R9: A written threshold is stored as the smallest legal value (0, 1, 2, 4, 8, 16, 32, 64) that is not below it, capped at 64. Address 2 reads back the stored value.
- R10: Status and enable bits outside the implemented map read as 0 and ignore writes and events. The event input at bit 16 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address (0 status, 1 enable, 2 threshold) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data, combinational from the read address |
| uframe_tick | input | 1 | One-cycle pulse per micro-frame |
| evt_pulse | input | 32 | Event pulses, one per status bit position |
| nak_level | input | 1 | Live NAK condition shown at status bit 16 |
| irq_o | output | 1 | Merged interrupt |

## Verification
The block is driven with several input patterns:
- Single immediate events, on enabled and on disabled bits. These separate posting from masking.
- An event in the same cycle as a clear of that bit. This shows whether set or clear wins.
- Completion events under thresholds 4 and 8, with status read one tick before and one tick at the boundary. These expose off-by-one counting and a counter that fails to restart.
- Writes of illegal thresholds, an all-ones event vector and a switch of the threshold to zero while events are pending. These cover rounding, masking of unimplemented bits and the flush of pending events.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;

    localparam int REG_W   = 32;
    localparam int THR_W   = 8;
    localparam int THR_MAX = 64;
    localparam int CNT_W   = $clog2(THR_MAX);
    localparam int NAK_BIT = 16;

    // immediate sources: bits 0..8, 24, 25
    localparam logic [REG_W-1:0] IMM_MASK = 32'h0300_01FF;
    // deferred completion sources: bit 18 async, bit 19 periodic
    localparam logic [REG_W-1:0] DEF_MASK = 32'h000C_0000;
    localparam logic [REG_W-1:0] NAK_MASK = 32'h0001_0000;
    localparam logic [REG_W-1:0] STS_MASK = IMM_MASK | DEF_MASK;
    localparam logic [REG_W-1:0] EN_MASK  = STS_MASK | NAK_MASK;

    typedef enum logic [1:0] {
        SEL_STS = 2'd0,
        SEL_EN  = 2'd1,
        SEL_THR = 2'd2,
        SEL_RSV = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             we;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } wr_req_t;

    // smallest legal threshold not below v, capped at THR_MAX
    function automatic logic [THR_W-1:0] round_thr(input logic [THR_W-1:0] v);
        logic [THR_W-1:0] r;
        r = THR_W'(THR_MAX);
        for (int k = CNT_W; k >= 0; k--) begin
            if (v <= THR_W'(1 << k)) r = THR_W'(1 << k);
        end
        if (v == '0) r = '0;
        return r;
    endfunction

endpackage

// File: rtl/irq_thr_timer.sv
module irq_thr_timer
    import irq_thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [THR_W-1:0] thr,
    output logic             boundary
);
    logic [CNT_W-1:0] cnt_q;
    logic             active;
    logic [THR_W-1:0] last_idx;

    assign active   = (thr != '0);
    assign last_idx = thr - THR_W'(1);
    assign boundary = tick && active && (THR_W'(cnt_q) == last_idx);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (boundary) begin
            cnt_q <= '0;
        end else if (tick && active) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R7: counter never runs past the programmed threshold
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (thr != '0) |-> (THR_W'(cnt_q) < thr));

    // R7: a boundary always returns the count to zero
    p_cnt_restart_r7: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (cnt_q == '0));
endmodule

// File: rtl/irq_thr_status.sv
module irq_thr_status
    import irq_thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt,
    input  logic [REG_W-1:0] clr,
    input  logic             thr_zero,
    input  logic             boundary,
    output logic [REG_W-1:0] sts
);
    logic [REG_W-1:0] sts_q, pend_q;
    logic [REG_W-1:0] imm_set, def_in, def_set, pend_d, sts_d;
    logic             deliver;

    assign imm_set = evt & IMM_MASK;
    assign def_in  = evt & DEF_MASK;
    assign deliver = thr_zero || boundary;
    assign def_set = deliver ? (pend_q | def_in) : '0;
    assign pend_d  = deliver ? '0 : (pend_q | def_in);
    // set wins over clear in the same cycle
    assign sts_d   = ((sts_q & ~clr) | imm_set | def_set) & STS_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '0;
            pend_q <= '0;
        end else begin
            sts_q  <= sts_d;
            pend_q <= pend_d & DEF_MASK;
        end
    end

    assign sts = sts_q;

    // R2: an immediate event is visible on the next edge
    p_sticky_set_r2: assert property (@(posedge clk) disable iff (rst)
        ((evt & IMM_MASK) != '0) |=> ((sts_q & $past(evt & IMM_MASK)) == $past(evt & IMM_MASK)));

    // R3: a cleared bit with no new event is zero afterwards
    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~evt) != '0) |=> ((sts_q & $past(clr & ~evt & IMM_MASK)) == '0));

    // R7: with a running threshold, deferred bits rise only at a boundary
    p_defer_r7: assert property (@(posedge clk) disable iff (rst)
        (!thr_zero && !boundary) |=> ((sts_q & DEF_MASK & ~$past(sts_q)) == '0));

    // R10: unimplemented positions stay zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (sts_q & ~STS_MASK) == '0);
endmodule

// File: rtl/irq_thr_ctrl.sv
module irq_thr_ctrl
    import irq_thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_waddr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [1:0]       reg_raddr,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             uframe_tick,
    input  logic [REG_W-1:0] evt_pulse,
    input  logic             nak_level,
    output logic             irq_o
);
    wr_req_t          wr;
    logic [REG_W-1:0] en_q, sts, sts_view, clr;
    logic [THR_W-1:0] thr_q;
    logic             thr_wr, boundary;

    assign wr.we   = reg_we;
    assign wr.sel  = reg_sel_e'(reg_waddr);
    assign wr.data = reg_wdata;

    assign thr_wr = wr.we && (wr.sel == SEL_THR);
    assign clr    = (wr.we && (wr.sel == SEL_STS)) ? (wr.data & STS_MASK) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            thr_q <= '0;
        end else begin
            if (wr.we && (wr.sel == SEL_EN)) en_q <= wr.data & EN_MASK;
            if (thr_wr) thr_q <= round_thr(wr.data[THR_W-1:0]);
        end
    end

    irq_thr_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (uframe_tick),
        .restart  (thr_wr),
        .thr      (thr_q),
        .boundary (boundary)
    );

    irq_thr_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .clr      (clr),
        .thr_zero (thr_q == '0),
        .boundary (boundary),
        .sts      (sts)
    );

    assign sts_view = sts | (nak_level ? NAK_MASK : '0);
    assign irq_o    = |(sts_view & en_q);

    always_comb begin
        unique case (reg_sel_e'(reg_raddr))
            SEL_STS: reg_rdata = sts_view;
            SEL_EN:  reg_rdata = en_q;
            SEL_THR: reg_rdata = REG_W'(thr_q);
            default: reg_rdata = '0;
        endcase
    end

    // R4: nothing enabled means no interrupt
    p_mask_all_r4: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_o);

    // R9: stored threshold is zero or a single power of two
    p_thr_legal_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(thr_q) && (thr_q <= THR_W'(THR_MAX)));

    // R1: state is cleared the cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (en_q == '0 && thr_q == '0));
endmodule

// File: tb/sim_irq_thr_ctrl.sv
module sim_irq_thr_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic        reg_we = 0;
    logic [1:0]  reg_waddr = 0;
    logic [31:0] reg_wdata = 0;
    logic [1:0]  reg_raddr = 0;
    logic [31:0] reg_rdata;
    logic        uframe_tick = 0;
    logic [31:0] evt_pulse = 0;
    logic        nak_level = 0;
    logic        irq_o;

    always #10 clk = ~clk; // 50 MHz

    irq_thr_ctrl u0 (.*);

    typedef struct {
        logic [1:0]  addr;
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    localparam logic [31:0] STS_ALL = 32'h030C_01FF;
    localparam logic [31:0] EN_ALL  = 32'h030D_01FF;

    // monitor: samples 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                total++;
                if (reg_rdata !== it.data || irq_o !== it.irq) begin
                    bad++;
                    $display("FAIL %s: addr=%0d data=%h irq=%b expected data=%h irq=%b",
                             it.tag, it.addr, reg_rdata, irq_o, it.data, it.irq);
                end
            end
        end
    end

    task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d,
                         input logic [31:0] e, input logic t);
        reg_we = we; reg_waddr = a; reg_wdata = d; evt_pulse = e; uframe_tick = t;
        @(negedge clk);
        reg_we = 0; evt_pulse = 0; uframe_tick = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 32'h0, 1'b0);
    endtask

    task automatic ev(input logic [31:0] e);
        drive(1'b0, 2'd0, 32'h0, e, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
    endtask

    task automatic chk(input logic [1:0] a, input logic [31:0] d, input logic irq, input string tag);
        exp_t it;
        reg_raddr = a;
        it.addr = a; it.data = d; it.irq = irq; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not end");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(2'd0, 32'h0, 1'b0, "R1 status");
        chk(2'd1, 32'h0, 1'b0, "R1 enable");
        chk(2'd2, 32'h0, 1'b0, "R1 threshold");

        // R10 enable mask
        wr(2'd1, 32'hFFFF_FFFF);
        chk(2'd1, EN_ALL, 1'b0, "R10 enable readback");

        // R2, R4 immediate event
        ev(32'h0000_0004);
        chk(2'd0, 32'h0000_0004, 1'b1, "R2 event posted");
        chk(2'd0, 32'h0000_0004, 1'b1, "R2 sticky");
        // R3 write zero then write one
        wr(2'd0, 32'h0);
        chk(2'd0, 32'h0000_0004, 1'b1, "R3 write zero keeps");
        wr(2'd0, 32'h0000_0004);
        chk(2'd0, 32'h0, 1'b0, "R3 write one clears");

        // R4 masked event
        wr(2'd1, 32'h0000_0001);
        ev(32'h0000_0002);
        chk(2'd0, 32'h0000_0002, 1'b0, "R4 disabled bit no irq");
        ev(32'h0000_0001);
        chk(2'd0, 32'h0000_0003, 1'b1, "R4 enabled bit irq");
        wr(2'd0, 32'h0000_0003);

        // R5 set wins
        wr(2'd1, 32'h0000_0020);
        drive(1'b1, 2'd0, 32'h0000_0020, 32'h0000_0020, 1'b0);
        chk(2'd0, 32'h0000_0020, 1'b1, "R5 set beats clear");
        wr(2'd0, 32'h0000_0020);

        // R6 nak level
        wr(2'd1, 32'h0001_0000);
        nak_level = 1;
        chk(2'd0, 32'h0001_0000, 1'b1, "R6 nak visible");
        wr(2'd0, 32'h0001_0000);
        chk(2'd0, 32'h0001_0000, 1'b1, "R6 nak not cleared");
        nak_level = 0;
        chk(2'd0, 32'h0, 1'b0, "R6 nak follows level");

        // R8 immediate completion with threshold 0
        wr(2'd1, EN_ALL);
        ev(32'h0004_0000);
        chk(2'd0, 32'h0004_0000, 1'b1, "R8 completion immediate");
        wr(2'd0, 32'h0004_0000);

        // R7 threshold 4
        wr(2'd2, 32'd4);
        chk(2'd2, 32'd4, 1'b0, "R9 legal value kept");
        ev(32'h000C_0000);
        ticks(3);
        chk(2'd0, 32'h0, 1'b0, "R7 held before boundary");
        ticks(1);
        chk(2'd0, 32'h000C_0000, 1'b1, "R7 posted at boundary");
        wr(2'd0, 32'h000C_0000);
        ev(32'h0008_0000);
        ticks(3);
        chk(2'd0, 32'h0, 1'b0, "R7 restarted count");
        ticks(1);
        chk(2'd0, 32'h0008_0000, 1'b1, "R7 second window");
        wr(2'd0, 32'h0008_0000);

        // R9 rounding
        wr(2'd2, 32'd3);
        chk(2'd2, 32'd4, 1'b0, "R9 3 rounds to 4");
        wr(2'd2, 32'd100);
        chk(2'd2, 32'd64, 1'b0, "R9 100 caps at 64");
        wr(2'd2, 32'd5);
        chk(2'd2, 32'd8, 1'b0, "R9 5 rounds to 8");
        ev(32'h0004_0000);
        ticks(7);
        chk(2'd0, 32'h0, 1'b0, "R9 threshold 8 held");
        ticks(1);
        chk(2'd0, 32'h0004_0000, 1'b1, "R9 threshold 8 boundary");
        wr(2'd0, 32'h0004_0000);

        // R8 flush on switch to zero
        wr(2'd2, 32'd4);
        ev(32'h0008_0000);
        chk(2'd0, 32'h0, 1'b0, "R8 pending held");
        wr(2'd2, 32'd0);
        chk(2'd0, 32'h0008_0000, 1'b1, "R8 pending flushed");
        wr(2'd0, 32'hFFFF_FFFF);
        chk(2'd0, 32'h0, 1'b0, "R3 clear all");

        // R10 unmapped bits
        ev(32'hFFFF_FFFF);
        chk(2'd0, STS_ALL, 1'b1, "R10 all-ones events masked");
        chk(2'd3, 32'h0, 1'b1, "R10 spare address reads zero");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule